// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight single-bit lock flags that two symmetric ports (left and right) use to coordinate access to a shared resource. A port claims a flag by writing to it and then reads the flag back to learn whether the claim succeeded. A flag that nobody holds reads as all ones from both sides. The holder reads its flag as all zeros, while the opposite port still reads all ones.

A claim on a flag that the other side holds is not lost. It stays pending and turns into ownership automatically in the cycle after the holder lets go. When both ports claim the same free flag on the same clock edge, a tie breaker grants it to exactly one of them. The side it favours flips after every tie, so neither port can be starved. The loser of a tie is left pending.

Both ports are sampled on one shared clock edge whenever their select input is high. Read data appears registered one cycle later.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous active-low reset, every flag is free and no claim is pending. Both read outputs show 8'hFF, and the first same-edge tie goes to the left port.
- R2: A selected write with data bit 0 equal to 0 claims the addressed flag. If the flag is free, the writing port owns it from the next clock edge, and a later read by that port returns 8'h00.
- R3: While a flag is owned, the opposite port reads it as 8'hFF.
- R4: A selected read (write strobe low) places the flag's state on the port's read output at the following edge, with all eight bits equal (8'h00 when owned by that port, 8'hFF otherwise). When no read is sampled, the read output keeps its value.
- R5: A selected write with data bit 0 equal to 1 releases the addressed flag if the writer owns it. A release write from a port that does not own the flag changes nothing.
- R6: A claim on a flag owned by the opposite port stays pending. The pending port becomes owner at the edge where the holder releases, with no further write.
- R7: Same-edge claims of one free flag grant it to exactly one port, and never to both or neither. The favoured side starts as left and alternates after every tie.
- R8: The 3-bit address selects one of eight independent flags. An operation on one flag leaves all the others unchanged.
- R9: With select low, the write strobe, address and data are ignored: no flag changes and the read output holds.
- R10: Left and right behave identically under any mix of operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_addr | input | 3 | Left flag address |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left registered read data |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe (1 write, 0 read) |
| r_addr | input | 3 | Right flag address |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right registered read data |

## Verification
Directed sequences exercise the claiming functions. A claim of a free flag shows that ownership is granted immediately. A claim of a held flag followed by its release separates a pending claim from a lost one. A release from the non-owner tells a checked release apart from an unconditional one. Two back-to-back ties on the same flag show whether the favoured side really alternates or stays fixed. Spreading claims over all eight addresses exposes address aliasing. Writes with select low check that unselected cycles are ignored. A long stretch of random traffic, concentrated on few addresses so that ties and pending claims are frequent, is compared on every clock against a behavioural model and exposes any asymmetry between the ports.

// File: rtl/sem_pkg.sv
// Shared types for the semaphore bank.
// Assumes: two ports only; the owner encoding is internal to the bank.
package sem_pkg;
    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;
endpackage

// File: rtl/sem_wr_decode.sv
// Turns one port's sampled write into one-hot claim and release vectors.
// Assumes: bit 0 of the write data carries the request (0 = claim, 1 = release).
module sem_wr_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic                 sel,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_FLAGS-1:0] claim,
    output logic [NUM_FLAGS-1:0] drop
);
    // one-hot decode of a selected write into claim or release
    always_comb begin
        claim = '0;
        drop  = '0;
        if (sel && wr) begin
            if (wdata[0]) drop[addr]  = 1'b1;
            else          claim[addr] = 1'b1;
        end
    end
endmodule

// File: rtl/sem_flag_cell.sv
// One semaphore flag: holder state plus a pending claim bit for each side.
// Assumes: at most one claim or release per side per cycle. The tie winner
// is chosen by the left_first input supplied by the bank-wide arbiter.
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim_l,
    input  logic claim_r,
    input  logic drop_l,
    input  logic drop_r,
    input  logic left_first,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r,
    output logic tie
);
    holder_e holder_q, holder_d;
    logic    want_l, want_r, freed;
    logic    pend_l_d, pend_r_d;

    // next holder: honour a release by the holder, then grant waiting claims
    always_comb begin
        want_l   = pend_l | claim_l;
        want_r   = pend_r | claim_r;
        freed    = (holder_q == HOLD_NONE) ||
                   (holder_q == HOLD_LEFT  && drop_l) ||
                   (holder_q == HOLD_RIGHT && drop_r);
        tie      = freed && want_l && want_r;
        holder_d = holder_q;
        if (freed) begin
            if (want_l && want_r) holder_d = left_first ? HOLD_LEFT : HOLD_RIGHT;
            else if (want_l)      holder_d = HOLD_LEFT;
            else if (want_r)      holder_d = HOLD_RIGHT;
            else                  holder_d = HOLD_NONE;
        end
        pend_l_d = want_l && (holder_d != HOLD_LEFT);
        pend_r_d = want_r && (holder_d != HOLD_RIGHT);
    end

    // state registers with synchronous reset to free and idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holder_q <= HOLD_NONE;
            pend_l   <= 1'b0;
            pend_r   <= 1'b0;
        end else begin
            holder_q <= holder_d;
            pend_l   <= pend_l_d;
            pend_r   <= pend_r_d;
        end
    end

    // holder view for each side
    always_comb begin
        own_l = (holder_q == HOLD_LEFT);
        own_r = (holder_q == HOLD_RIGHT);
    end
endmodule

// File: rtl/sem_tie_arb.sv
// Bank-wide tie breaker: one favoured side that flips after every tie.
// Assumes: the tie vector is resolved in the same cycle using left_first.
module sem_tie_arb #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] tie_vec,
    output logic                 left_first
);
    // alternate the favoured side whenever any flag had a tie
    always_ff @(posedge clk) begin
        if (!rst_n)      left_first <= 1'b1;
        else if (|tie_vec) left_first <= ~left_first;
    end
endmodule

// File: rtl/sem_read_port.sv
// Registered read path for one port: replicates the flag view over the bus.
// Assumes: a read is a selected cycle with the write strobe low.
module sem_read_port #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_FLAGS-1:0] own_me,
    output logic [DATA_W-1:0]    rdata
);
    // capture the selected flag as all zeros if held by this side, else all ones
    always_ff @(posedge clk) begin
        if (!rst_n)           rdata <= '1;
        else if (sel && !wr)  rdata <= {DATA_W{~own_me[addr]}};
    end
endmodule

// File: rtl/sem_bank.sv
// Two-port semaphore bank: NUM_FLAGS lock flags, claim by write, check by read.
// Assumes: both ports share clk; operations are sampled when the select is high.
module sem_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NUM_FLAGS-1:0] claim_l_v, claim_r_v, drop_l_v, drop_r_v;
    logic [NUM_FLAGS-1:0] own_l_v, own_r_v, pend_l_v, pend_r_v, tie_v;
    logic                 left_first;

    sem_wr_decode #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_l (
        .sel(l_sel), .wr(l_wr), .addr(l_addr), .wdata(l_wdata),
        .claim(claim_l_v), .drop(drop_l_v)
    );

    sem_wr_decode #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_r (
        .sel(r_sel), .wr(r_wr), .addr(r_addr), .wdata(r_wdata),
        .claim(claim_r_v), .drop(drop_r_v)
    );

    sem_tie_arb #(.NUM_FLAGS(NUM_FLAGS)) u_arb (
        .clk(clk), .rst_n(rst_n), .tie_vec(tie_v), .left_first(left_first)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sem_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .claim_l(claim_l_v[g]), .claim_r(claim_r_v[g]),
            .drop_l(drop_l_v[g]),   .drop_r(drop_r_v[g]),
            .left_first(left_first),
            .own_l(own_l_v[g]), .own_r(own_r_v[g]),
            .pend_l(pend_l_v[g]), .pend_r(pend_r_v[g]),
            .tie(tie_v[g])
        );
    end

    sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .sel(l_sel), .wr(l_wr), .addr(l_addr),
        .own_me(own_l_v), .rdata(l_rdata)
    );

    sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .sel(r_sel), .wr(r_wr), .addr(r_addr),
        .own_me(own_r_v), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
// Property checker for sem_bank, attached by the bind at the end of this file.
// Assumes: sees the bank's ports plus its holder, pending and tie vectors.
module sem_bank_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sel,
    input logic                 l_wr,
    input logic [ADDR_W-1:0]    l_addr,
    input logic [DATA_W-1:0]    l_rdata,
    input logic                 r_sel,
    input logic                 r_wr,
    input logic [ADDR_W-1:0]    r_addr,
    input logic [DATA_W-1:0]    r_rdata,
    input logic [NUM_FLAGS-1:0] own_l_v,
    input logic [NUM_FLAGS-1:0] own_r_v,
    input logic [NUM_FLAGS-1:0] pend_l_v,
    input logic [NUM_FLAGS-1:0] pend_r_v,
    input logic [NUM_FLAGS-1:0] tie_v,
    input logic                 left_first
);
    p_uniform_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0) || (l_rdata == '1));

    p_uniform_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rdata == '0) || (r_rdata == '1));

    p_hold_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_sel && !l_wr) |=> $stable(l_rdata));

    p_hold_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_sel && !r_wr) |=> $stable(r_rdata));

    p_single_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_wr && r_sel && !r_wr && l_addr == r_addr)
        |=> !(l_rdata == '0 && r_rdata == '0));

    p_pend_blocked_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_l_v & ~own_r_v) == '0);

    p_pend_blocked_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_r_v & ~own_l_v) == '0);

    p_tie_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|tie_v) |=> (left_first != $past(left_first)));

    p_no_tie_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|tie_v) |=> $stable(left_first));
endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_rdata(r_rdata),
    .own_l_v(own_l_v), .own_r_v(own_r_v),
    .pend_l_v(pend_l_v), .pend_r_v(pend_r_v),
    .tie_v(tie_v), .left_first(left_first)
);

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel = 1'b0, l_wr = 1'b0, r_sel = 1'b0, r_wr = 1'b0;
    logic [2:0] l_addr = '0, r_addr = '0;
    logic [7:0] l_wdata = '0, r_wdata = '0;
    logic [7:0] l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model: holder 0 free, 1 left, 2 right
    int   m_hold [8];
    bit   m_pl [8];
    bit   m_pr [8];
    bit   m_lfirst;
    logic [7:0] m_rl, m_rr;

    always #5 clk = ~clk;

    sem_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_hold[i] = 0; m_pl[i] = 0; m_pr[i] = 0;
        end
        m_lfirst = 1; m_rl = 8'hFF; m_rr = 8'hFF;
    endtask

    task automatic model_step();
        bit want_l, want_r, free_now;
        if (l_sel && !l_wr) m_rl = (m_hold[l_addr] == 1) ? 8'h00 : 8'hFF;
        if (r_sel && !r_wr) m_rr = (m_hold[r_addr] == 2) ? 8'h00 : 8'hFF;
        for (int i = 0; i < 8; i++) begin
            want_l = m_pl[i] || (l_sel && l_wr && l_addr == i && !l_wdata[0]);
            want_r = m_pr[i] || (r_sel && r_wr && r_addr == i && !r_wdata[0]);
            free_now = (m_hold[i] == 0) ||
                (m_hold[i] == 1 && l_sel && l_wr && l_addr == i && l_wdata[0]) ||
                (m_hold[i] == 2 && r_sel && r_wr && r_addr == i && r_wdata[0]);
            if (free_now) begin
                if (want_l && want_r) begin
                    m_hold[i] = m_lfirst ? 1 : 2;
                    m_lfirst = !m_lfirst;
                end else if (want_l) m_hold[i] = 1;
                else if (want_r)     m_hold[i] = 2;
                else                 m_hold[i] = 0;
            end
            m_pl[i] = want_l && m_hold[i] != 1;
            m_pr[i] = want_r && m_hold[i] != 2;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (l_rdata !== m_rl) begin
            errors++;
            $display("FAIL %s left rdata actual %h expected %h", tag, l_rdata, m_rl);
        end
        checks++;
        if (r_rdata !== m_rr) begin
            errors++;
            $display("FAIL %s right rdata actual %h expected %h", tag, r_rdata, m_rr);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit ls, input bit lw, input int la, input bit ld,
                        input bit rs, input bit rw, input int ra, input bit rd,
                        input string tag);
        l_sel = ls; l_wr = lw; l_addr = la[2:0]; l_wdata = {7'h55, ld};
        r_sel = rs; r_wr = rw; r_addr = ra[2:0]; r_wdata = {7'h2A, rd};
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step(1, 0, i, 0, 1, 0, i, 0, "R1");

        // R2/R3: left claims flag 3, both read
        step(1, 1, 3, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 3, 0, 1, 0, 3, 0, "R2");
        step(0, 0, 0, 0, 1, 0, 3, 0, "R3");
        // R5: right releases flag it does not own
        step(0, 0, 0, 0, 1, 1, 3, 1, "R5");
        step(1, 0, 3, 0, 1, 0, 3, 0, "R5");
        // R6: right claims held flag, left releases, right gets it
        step(0, 0, 0, 0, 1, 1, 3, 0, "R6");
        step(1, 0, 3, 0, 1, 0, 3, 0, "R6");
        step(1, 1, 3, 1, 0, 0, 0, 0, "R6");
        step(1, 0, 3, 0, 1, 0, 3, 0, "R6");
        step(0, 0, 0, 0, 1, 1, 3, 1, "R5");
        step(1, 0, 3, 0, 1, 0, 3, 0, "R5");

        // R7: tie twice on flag 5, winner alternates
        step(1, 1, 5, 0, 1, 1, 5, 0, "R7");
        step(1, 0, 5, 0, 1, 0, 5, 0, "R7");
        step(1, 1, 5, 1, 0, 0, 0, 0, "R7");
        step(1, 0, 5, 0, 1, 0, 5, 0, "R7");
        step(0, 0, 0, 0, 1, 1, 5, 1, "R7");
        step(1, 1, 5, 0, 1, 1, 5, 0, "R7");
        step(1, 0, 5, 0, 1, 0, 5, 0, "R7");
        step(0, 0, 0, 0, 1, 1, 5, 1, "R7");
        step(1, 0, 5, 0, 1, 0, 5, 0, "R7");
        step(1, 1, 5, 1, 0, 0, 0, 0, "R7");

        // R9: unselected writes ignored, read output holds
        step(0, 1, 0, 0, 0, 1, 1, 0, "R9");
        step(1, 0, 0, 0, 1, 0, 1, 0, "R9");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R4");

        // R8: left takes even flags, right takes odd flags
        for (int i = 0; i < 8; i += 2) step(1, 1, i, 0, 1, 1, i + 1, 0, "R8");
        for (int i = 0; i < 8; i++) step(1, 0, i, 0, 1, 0, i, 0, "R8");
        for (int i = 0; i < 8; i += 2) step(1, 1, i, 1, 1, 1, i + 1, 1, "R8");
        for (int i = 0; i < 8; i++) step(1, 0, i, 0, 1, 0, i, 0, "R8");

        // R10: random traffic on few flags, compared each clock
        for (int n = 0; n < 4000; n++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 2),
                 $urandom_range(0, 1),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 2),
                 $urandom_range(0, 1), "R10");
        end
        idle("R4");

        // R1: reset mid-run frees everything
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(1, 0, i, 0, 1, 0, i, 0, "R1");
        step(1, 1, 2, 0, 1, 1, 2, 0, "R1");
        step(1, 0, 2, 0, 1, 0, 2, 0, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule